// File: doc/BRIEF.md
# Medium Reservation Timer

This block holds the virtual carrier-sense reservation of a wireless MAC. A frame parser reports each received frame as a one-cycle event that carries a frame kind and the duration field, in microseconds. When the frame is a request-to-send, clear-to-send or data frame, the duration states how much of the four-frame exchange is still to come. The block loads that value into a reservation counter. The counter then counts down on a free-running microsecond tick. While the count is non-zero, the block reports the medium as busy so that the station defers. A newly reported duration only ever lengthens the reservation.

An exchange watchdog guards against a handshake that stalls. Every reserving frame restarts it. If the next reserving frame does not arrive within a programmable number of ticks, the watchdog wipes the reservation. The watchdog disarms itself once the count reaches zero on its own.

When the reservation ends, the block raises a one-cycle transmit-go pulse, but only while the backoff engine is idle. If backoff is running at that moment, the go is held back and released when backoff ends, provided no new reservation has arrived in the meantime.

Top module: `medium_resv_timer`

## Requirements
- R1: A synchronous reset clears the reservation count and disarms the watchdog. During reset and after it, `medium_busy` and `tx_go` stay low until a reservation is loaded and ends.
- R2: A frame event whose kind is RTS (code 0), CTS (code 1) or DATA (code 2) loads its duration into the count when the duration is larger than the count would otherwise have in the next cycle.
- R3: A reserving frame whose duration is not larger than the current count leaves the count as it is, so the reservation never shrinks.
- R4: A frame event of kind code 3 (any other frame) has no effect on the count.
- R5: Each cycle with `us_tick` high lowers a non-zero count by one. A count of zero stays at zero.
- R6: `medium_busy` is high exactly while the count is non-zero. It follows the clock edge at which the count changes.
- R7: Each reserving frame restarts the watchdog. With `wd_limit` = L and L not zero, if the count is still non-zero at the L-th tick after the last reserving frame, the count is forced to zero at that edge. With L = 0 the watchdog never fires.
- R8: When the count becomes zero, by ticking down or by a watchdog clear, and `backoff_busy` is low, `tx_go` is high for exactly one cycle: the cycle after that edge.
- R9: If `backoff_busy` is high when the count becomes zero, `tx_go` is withheld. It rises in the first cycle with `backoff_busy` low, for one cycle, provided the count has stayed zero. A new reservation in between cancels the withheld go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | One-cycle received-frame event |
| frm_kind | input | 2 | Frame kind: 0 RTS, 1 CTS, 2 DATA, 3 other |
| frm_dur | input | CNT_W | Duration field in microseconds |
| us_tick | input | 1 | One-cycle microsecond strobe |
| backoff_busy | input | 1 | Backoff countdown in progress |
| wd_limit | input | WD_W | Watchdog timeout in ticks; 0 disables it |
| medium_busy | output | 1 | Reservation active; defer transmission |
| tx_go | output | 1 | One-cycle permission to start a transmission |

## Verification
A frame or a tick presented in one cycle changes `medium_busy` just after the next rising edge. The bench therefore drives inputs at the falling edge and reads outputs at the following falling edge. For a load of D with no watchdog, the busy flag is expected high after tick D-1 and low after tick D. In the same sampling window as that low reading, `tx_go` is expected high, and it is expected low one step later. `tx_go` follows `backoff_busy` without a register stage. Withheld go pulses are therefore checked in the same window where backoff is dropped. Watchdog clears are expected at exactly the L-th tick counted from the last reserving frame.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

   typedef enum logic [1:0] {
      FK_RTS   = 2'd0,
      FK_CTS   = 2'd1,
      FK_DATA  = 2'd2,
      FK_OTHER = 2'd3
   } frame_kind_e;

   function automatic logic kind_reserves(input logic [1:0] kind);
      return (kind == FK_RTS) || (kind == FK_CTS) || (kind == FK_DATA);
   endfunction

endpackage

// File: rtl/mrt_counter.sv
module mrt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_req,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             force_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             cnt_zero
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] stepped;
   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      stepped = (tick && (cnt != ZERO)) ? (cnt - ONE) : cnt;
      base    = force_clr ? ZERO : stepped;
      nxt     = (load_req && (load_val > base)) ? load_val : base;
   end

   always_ff @(posedge clk) begin
      if (rst) cnt <= ZERO;
      else     cnt <= nxt;
   end

   assign cnt_zero = (cnt == ZERO);

   AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
      (tick && !load_req && !force_clr && (cnt != ZERO)) |=> (cnt == $past(cnt) - ONE)); // R5
   AST_ZERO_SATURATE: assert property (@(posedge clk) disable iff (rst)
      (cnt_zero && !load_req) |=> cnt_zero); // R5
   AST_LOAD_REACH: assert property (@(posedge clk) disable iff (rst)
      load_req |=> (cnt >= $past(load_val))); // R2
   AST_NO_SHORTEN: assert property (@(posedge clk) disable iff (rst)
      (load_req && !force_clr && !tick) |=> (cnt >= $past(cnt))); // R3
   AST_WD_WIPE: assert property (@(posedge clk) disable iff (rst)
      (force_clr && !load_req) |=> cnt_zero); // R7

endmodule

// File: rtl/mrt_wdog.sv
module mrt_wdog #(
   parameter int WD_W    = 16,
   parameter bit ON_TICK = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            restart,
   input  logic            tick,
   input  logic            resv_zero,
   input  logic [WD_W-1:0] limit,
   output logic            expire,
   output logic            armed
);

   localparam logic [WD_W:0] ONE_X = {{WD_W{1'b0}}, 1'b1};

   logic            advance;
   logic [WD_W-1:0] elapsed;
   logic [WD_W:0]   after_step;

   generate
      if (ON_TICK) begin : g_tick_base
         assign advance = tick;
      end else begin : g_clock_base
         assign advance = 1'b1;
      end
   endgenerate

   assign after_step = {1'b0, elapsed} + ONE_X;

   always_comb begin
      expire = armed && !restart && advance && !resv_zero &&
               (limit != '0) && (after_step == {1'b0, limit});
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         armed   <= 1'b0;
         elapsed <= '0;
      end else if (restart) begin
         armed   <= 1'b1;
         elapsed <= '0;
      end else if (expire || resv_zero) begin
         armed   <= 1'b0;
         elapsed <= '0;
      end else if (armed && advance) begin
         elapsed <= after_step[WD_W-1:0];
      end
   end

   AST_WD_REARM: assert property (@(posedge clk) disable iff (rst)
      restart |=> armed); // R7
   AST_WD_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
      expire |=> (!armed && !expire)); // R7

endmodule

// File: rtl/mrt_permit.sv
module mrt_permit (
   input  logic clk,
   input  logic rst,
   input  logic cnt_zero,
   input  logic backoff,
   output logic go
);

   logic was_busy;
   logic withheld;
   logic ended;
   logic wanted;

   always_comb begin
      ended  = was_busy && cnt_zero;
      wanted = (ended || withheld) && cnt_zero;
      go     = wanted && !backoff;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         was_busy <= 1'b0;
         withheld <= 1'b0;
      end else begin
         was_busy <= !cnt_zero;
         withheld <= wanted && backoff;
      end
   end

   AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
      go |=> !go); // R8

endmodule

// File: rtl/medium_resv_timer.sv
module medium_resv_timer #(
   parameter int CNT_W      = 16,
   parameter int WD_W       = 16,
   parameter bit WD_ON_TICK = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frm_valid,
   input  logic [1:0]       frm_kind,
   input  logic [CNT_W-1:0] frm_dur,
   input  logic             us_tick,
   input  logic             backoff_busy,
   input  logic [WD_W-1:0]  wd_limit,
   output logic             medium_busy,
   output logic             tx_go
);
   import mrt_pkg::*;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("medium_resv_timer: CNT_W must be 2..32");
      end
      if (WD_W < 1 || WD_W > 32) begin : g_bad_wd_w
         $error("medium_resv_timer: WD_W must be 1..32");
      end
   endgenerate

   logic             qualify;
   logic             wd_fire;
   logic             wd_armed;
   logic [CNT_W-1:0] resv_cnt;
   logic             resv_zero;

   assign qualify = frm_valid && kind_reserves(frm_kind);

   mrt_counter #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst      (rst),
      .load_req (qualify),
      .load_val (frm_dur),
      .tick     (us_tick),
      .force_clr(wd_fire),
      .cnt      (resv_cnt),
      .cnt_zero (resv_zero)
   );

   mrt_wdog #(.WD_W(WD_W), .ON_TICK(WD_ON_TICK)) u_wdog (
      .clk      (clk),
      .rst      (rst),
      .restart  (qualify),
      .tick     (us_tick),
      .resv_zero(resv_zero),
      .limit    (wd_limit),
      .expire   (wd_fire),
      .armed    (wd_armed)
   );

   mrt_permit u_permit (
      .clk     (clk),
      .rst     (rst),
      .cnt_zero(resv_zero),
      .backoff (backoff_busy),
      .go      (tx_go)
   );

   assign medium_busy = !resv_zero;

   AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (frm_valid && (frm_kind == FK_OTHER) && !us_tick && !wd_fire) |=> $stable(resv_cnt)); // R4
   AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
      tx_go |-> (!medium_busy && !backoff_busy)); // R9
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!medium_busy && !wd_armed)); // R1

endmodule

// File: tb/sim_medium_resv_timer.sv
module sim_medium_resv_timer;
   localparam int CLK_P = 10;
   localparam int CW    = 16;
   localparam int WW    = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          frm_valid = 1'b0;
   logic [1:0]    frm_kind = 2'd3;
   logic [CW-1:0] frm_dur = '0;
   logic          us_tick = 1'b0;
   logic          backoff_busy = 1'b0;
   logic [WW-1:0] wd_limit = '0;
   logic          medium_busy;
   logic          tx_go;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   medium_resv_timer #(.CNT_W(CW), .WD_W(WW), .WD_ON_TICK(1'b1)) u0 (
      .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_kind(frm_kind),
      .frm_dur(frm_dur), .us_tick(us_tick), .backoff_busy(backoff_busy),
      .wd_limit(wd_limit), .medium_busy(medium_busy), .tx_go(tx_go));

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: inputs held across the rising edge, outputs read at the next falling edge
   task automatic step(input logic tk, input logic fv, input logic [1:0] fk, input int dur);
      us_tick   = tk;
      frm_valid = fv;
      frm_kind  = fk;
      frm_dur   = dur[CW-1:0];
      @(negedge clk);
      us_tick   = 1'b0;
      frm_valid = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd3, 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      chk("R1 busy in reset", medium_busy, 1'b0);
      chk("R1 go in reset", tx_go, 1'b0);
      rst = 1'b0;
      step(1'b0, 1'b0, 2'd3, 0);
      ticks(3);
      chk("R1 busy after reset", medium_busy, 1'b0);
      chk("R1 go after reset", tx_go, 1'b0);

      // R2 R5 R6 R8: sweep kinds 0..2 and durations 1..6, watchdog off
      wd_limit = '0;
      for (int k = 0; k < 3; k++) begin
         for (int d = 1; d <= 6; d++) begin
            step(1'b0, 1'b1, k[1:0], d);
            chk("R2 load sets busy", medium_busy, 1'b1);
            for (int i = 1; i <= d; i++) begin
               step(1'b1, 1'b0, 2'd3, 0);
               if (i < d) begin
                  chk("R6 busy while counting", medium_busy, 1'b1);
                  chk("R8 no go while counting", tx_go, 1'b0);
               end else begin
                  chk("R5 reaches zero after D ticks", medium_busy, 1'b0);
                  chk("R8 go at end", tx_go, 1'b1);
               end
            end
            step(1'b1, 1'b0, 2'd3, 0);
            chk("R8 go single cycle", tx_go, 1'b0);
            chk("R5 saturates at zero", medium_busy, 1'b0);
         end
      end

      // R3: shorter duration does not shrink 10
      step(1'b0, 1'b1, 2'd0, 10);
      step(1'b0, 1'b1, 2'd2, 4);
      ticks(9);
      chk("R3 not shortened", medium_busy, 1'b1);
      ticks(1);
      chk("R3 ends at original", medium_busy, 1'b0);
      chk("R8 go after R3 case", tx_go, 1'b1);
      // R2: longer duration extends 6 to 12
      step(1'b0, 1'b1, 2'd1, 6);
      step(1'b0, 1'b1, 2'd0, 12);
      ticks(11);
      chk("R2 extended", medium_busy, 1'b1);
      ticks(1);
      chk("R2 extended end", medium_busy, 1'b0);

      // R4: other-kind frames ignored
      step(1'b0, 1'b1, 2'd3, 50);
      chk("R4 idle stays free", medium_busy, 1'b0);
      chk("R4 no go", tx_go, 1'b0);
      step(1'b0, 1'b1, 2'd2, 5);
      step(1'b0, 1'b1, 2'd3, 100);
      ticks(4);
      chk("R4 count unchanged", medium_busy, 1'b1);
      ticks(1);
      chk("R4 ends at 5", medium_busy, 1'b0);

      // R7: watchdog clears a stalled reservation
      wd_limit = 16'd5;
      step(1'b0, 1'b1, 2'd0, 100);
      ticks(4);
      chk("R7 busy before timeout", medium_busy, 1'b1);
      ticks(1);
      chk("R7 cleared at L ticks", medium_busy, 1'b0);
      chk("R8 go after wipe", tx_go, 1'b1);
      step(1'b0, 1'b0, 2'd3, 0);
      chk("R8 wipe go single", tx_go, 1'b0);
      // R7: restart on every reserving frame
      step(1'b0, 1'b1, 2'd0, 100);
      ticks(3);
      step(1'b0, 1'b1, 2'd1, 50);
      ticks(4);
      chk("R7 restarted", medium_busy, 1'b1);
      ticks(1);
      chk("R7 cleared after restart", medium_busy, 1'b0);
      // R7: limit zero disables
      wd_limit = '0;
      step(1'b0, 1'b1, 2'd2, 20);
      ticks(19);
      chk("R7 disabled watchdog", medium_busy, 1'b1);
      ticks(1);
      chk("R7 natural end", medium_busy, 1'b0);

      // R9: go withheld during backoff
      backoff_busy = 1'b1;
      step(1'b0, 1'b1, 2'd0, 3);
      ticks(3);
      chk("R9 free during backoff", medium_busy, 1'b0);
      chk("R9 go held", tx_go, 1'b0);
      ticks(2);
      chk("R9 still held", tx_go, 1'b0);
      backoff_busy = 1'b0;
      #1;
      chk("R9 go on release", tx_go, 1'b1);
      step(1'b0, 1'b0, 2'd3, 0);
      chk("R9 release go single", tx_go, 1'b0);
      // R9: new reservation cancels a withheld go
      backoff_busy = 1'b1;
      step(1'b0, 1'b1, 2'd0, 2);
      ticks(2);
      step(1'b0, 1'b1, 2'd1, 4);
      backoff_busy = 1'b0;
      #1;
      chk("R9 cancelled go", tx_go, 1'b0);
      chk("R9 busy again", medium_busy, 1'b1);
      ticks(4);
      chk("R9 go after new end", tx_go, 1'b1);
      step(1'b0, 1'b0, 2'd3, 0);
      chk("R9 single after cancel", tx_go, 1'b0);

      // R1: reset mid-reservation
      step(1'b0, 1'b1, 2'd0, 30);
      rst = 1'b1;
      step(1'b0, 1'b0, 2'd3, 0);
      chk("R1 reset clears busy", medium_busy, 1'b0);
      rst = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step(1'b1, 1'b0, 2'd3, 0);
         chk("R1 no go after reset", tx_go, 1'b0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule